// File: doc/BRIEF.md
# DSD Bitstream Fault Monitor

This block observes a single-channel one-bit delta-sigma (DSD) stream, taking one bit on each cycle where the bit strobe is high. It looks for two kinds of corrupted stream. The first is a stuck stream, where the same bit value repeats without a break. This raises a mute request. The second is a stream whose recent history leans too far toward one value. This raises an attenuate request. Both requests are registered flags that a downstream data path acts on.

A small control register holds three settings: a stuck-run detector enable, a density detector enable, and a direct-conversion bypass. The whole register is loaded in one cycle through a write strobe. The bypass setting stands for the path that sends the stream straight to the converter with no processing. In that mode attenuation cannot be applied, so the attenuate request is held low. The mute request is unaffected by bypass.

Top module: `dsd_fault_monitor`

## Requirements
- R1: After reset both request outputs are 0, the run detector is enabled, the density detector is disabled and bypass is off.
- R2: With the run detector enabled, `mute_req` is 1 in the cycle after the 28th consecutive accepted bit of the same value is sampled. After only 27 such bits it is still 0.
- R3: `mute_req` returns to 0 in the cycle after the first accepted bit that differs from the previous accepted bit.
- R4: While the run continues past 28 bits, `mute_req` stays at 1. The run length saturates at 28.
- R5: With the density detector enabled, `atten_req` is 1 in the cycle after a sample leaves the last 28 accepted bits holding more than 24 ones or fewer than 4 ones. A window holding exactly 24 ones or exactly 4 ones does not raise it.
- R6: `atten_req` stays 0 until 28 bits have been accepted since reset or since the density detector was last enabled.
- R7: `atten_req` returns to 0 in the cycle after a sample that brings the window count back into the range 4 to 24.
- R8: When a detector's enable is 0, that detector's output is 0 from the second clock edge after the write onward. Its history is discarded, and counting restarts from nothing when it is enabled again.
- R9: While bypass is 1, `atten_req` is 0. The density detector keeps its state, so a biased window shows on `atten_req` again once bypass returns to 0. `mute_req` is not affected by bypass.
- R10: A cycle with `bit_valid` at 0 changes no detector state, whatever the value on `bit_in`.
- R11: The control settings change only on a cycle where `cfg_we` is 1. On that cycle all three are loaded from the `cfg_*` inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | Strobe: `bit_in` is accepted on this cycle |
| bit_in | input | 1 | DSD stream bit |
| cfg_we | input | 1 | Loads the control register from the three `cfg_*` inputs |
| cfg_static_en | input | 1 | Value to load for the stuck-run detector enable |
| cfg_invalid_en | input | 1 | Value to load for the density detector enable |
| cfg_bypass | input | 1 | Value to load for the direct-conversion bypass |
| mute_req | output | 1 | Registered mute request from the stuck-run detector |
| atten_req | output | 1 | Registered attenuate request from the density detector, held low in bypass |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Run length boundary.** The bench sends 27 identical bits, then the 28th. An off-by-one counter mutes one bit early or one bit late.
- **Run continues past 28 bits.** A counter that wraps instead of saturating drops the mute in the middle of a stuck run.
- **Density thresholds.** The bench fills the window to 25 ones and then lets it slide to exactly 24 ones. The low side at 3 and 4 ones is tested the same way. A design that compares with the wrong operator flags on the boundary count, or keeps flagging once the window leaves the fault range.
- **Partly filled window and enable changes.** The bench checks the window before it holds 28 bits, and again after an enable is cleared and set. A design that evaluates a partial window, or keeps stale history, flags too early.
- **Bypass.** The bench toggles bypass over a biased window. A design that gates the detector instead of the output loses the flag, or wrongly suppresses the mute.

// File: rtl/dsd_mon_pkg.sv
// Shared types for the DSD fault monitor.
// Assumes: one control register whose fields load together on one write.
package dsd_mon_pkg;

    // Control register contents
    typedef struct packed {
        logic static_en;   // stuck-run detector enable
        logic invalid_en;  // density detector enable
        logic bypass;      // direct-conversion path selected
    } mon_cfg_t;

    // Value the control register takes in reset
    localparam mon_cfg_t CFG_RESET = '{static_en: 1'b1, invalid_en: 1'b0, bypass: 1'b0};

endpackage

// File: rtl/dsd_mon_cfg.sv
// Control register for the fault monitor.
// Assumes: all fields are written together when wr_en is high; reset loads CFG_RESET.
module dsd_mon_cfg
    import dsd_mon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  mon_cfg_t wr_data,
    output mon_cfg_t cfg_q
);

    // Hold the control settings; load on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q <= wr_data;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> cfg_q == $past(cfg_q)); // R11

endmodule

// File: rtl/dsd_run_detect.sv
// Stuck-stream detector: counts accepted bits equal to the previous one.
// The run length saturates at RUN_LEN. The hit flag is registered and is high
// while the run is at least RUN_LEN bits long.
// Assumes: en is a registered level. While en is low, all history is discarded.
module dsd_run_detect #(
    parameter int RUN_LEN = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_valid,
    input  logic bit_in,
    output logic run_hit
);

    localparam int CW = $clog2(RUN_LEN + 1);

    logic          prev_bit;
    logic          have_prev;
    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_nxt;

    // Next run length: restart on a change, saturate at the limit
    always_comb begin
        if (!have_prev || (bit_in != prev_bit)) begin
            run_nxt = CW'(1);
        end else if (run_cnt == CW'(RUN_LEN)) begin
            run_nxt = run_cnt;
        end else begin
            run_nxt = run_cnt + CW'(1);
        end
    end

    // Update the run history and flag on each accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            prev_bit  <= 1'b0;
            have_prev <= 1'b0;
            run_cnt   <= '0;
            run_hit   <= 1'b0;
        end else if (bit_valid) begin
            prev_bit  <= bit_in;
            have_prev <= 1'b1;
            run_cnt   <= run_nxt;
            run_hit   <= (run_nxt == CW'(RUN_LEN));
        end
    end

    AST_RUN_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(RUN_LEN)); // R4
    AST_MUTE_CLEAR_ON_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_valid && have_prev && (bit_in != prev_bit)) |=> !run_hit); // R3
    AST_MUTE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !run_hit); // R8
    AST_RUN_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_valid) |=> ($stable(run_cnt) && $stable(run_hit))); // R10

endmodule

// File: rtl/dsd_window_detect.sv
// Density detector: keeps the last WIN accepted bits and a running count of
// ones. The count is updated by adding the new bit and removing the bit that
// leaves the window. The flag is registered and is high when the window is
// full and its ones count is above HI or below WIN-HI.
// Assumes: en is a registered level. While en is low, all history is discarded
// and the window must refill before it is judged.
module dsd_window_detect #(
    parameter int WIN = 28,
    parameter int HI  = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_valid,
    input  logic bit_in,
    output logic bias_hit
);

    localparam int OW = $clog2(WIN + 1);
    localparam int LO = WIN - HI;

    logic [WIN-1:0] hist;
    logic [OW-1:0]  ones;
    logic [OW-1:0]  ones_nxt;
    logic [OW-1:0]  fill;
    logic [OW-1:0]  fill_nxt;
    logic           oldest;
    logic           dense;

    // Running count, fill level and threshold test for the next window
    always_comb begin
        oldest   = hist[WIN-1];
        ones_nxt = ones + OW'(bit_in) - OW'(oldest);
        fill_nxt = (fill == OW'(WIN)) ? fill : fill + OW'(1);
        dense    = (fill_nxt == OW'(WIN)) &&
                   ((ones_nxt > OW'(HI)) || (ones_nxt < OW'(LO)));
    end

    // Shift the window and register the flag on each accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hist     <= '0;
            ones     <= '0;
            fill     <= '0;
            bias_hit <= 1'b0;
        end else if (bit_valid) begin
            hist     <= {hist[WIN-2:0], bit_in};
            ones     <= ones_nxt;
            fill     <= fill_nxt;
            bias_hit <= dense;
        end
    end

    AST_ONES_MATCH_HIST: assert property (@(posedge clk) disable iff (!rst_n)
        ones == OW'($countones(hist))); // R5
    AST_ONES_LE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= fill); // R5
    AST_FLAG_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        bias_hit |-> (fill == OW'(WIN))); // R6
    AST_ATTEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bias_hit); // R8
    AST_WIN_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_valid) |=> ($stable(ones) && $stable(bias_hit))); // R10

endmodule

// File: rtl/dsd_fault_monitor.sv
// DSD bitstream fault monitor top level.
// Combines the control register, the stuck-run detector (mute request) and the
// density detector (attenuate request). Bypass masks only the attenuate output;
// the detector state behind it is kept.
// Assumes: the control fields take effect one clock after they are written.
module dsd_fault_monitor
    import dsd_mon_pkg::*;
#(
    parameter int RUN_LEN = 28,
    parameter int WIN     = 28,
    parameter int HI      = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic cfg_we,
    input  logic cfg_static_en,
    input  logic cfg_invalid_en,
    input  logic cfg_bypass,
    output logic mute_req,
    output logic atten_req
);

    mon_cfg_t cfg_wr;
    mon_cfg_t cfg_q;
    logic     run_hit;
    logic     bias_hit;

    // Gather the write data into one register image
    always_comb begin
        cfg_wr.static_en  = cfg_static_en;
        cfg_wr.invalid_en = cfg_invalid_en;
        cfg_wr.bypass     = cfg_bypass;
    end

    dsd_mon_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wr),
        .cfg_q   (cfg_q)
    );

    dsd_run_detect #(.RUN_LEN(RUN_LEN)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_q.static_en),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .run_hit   (run_hit)
    );

    dsd_window_detect #(.WIN(WIN), .HI(HI)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_q.invalid_en),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .bias_hit  (bias_hit)
    );

    // Drive the requests: mute passes straight through, attenuate is masked in bypass
    always_comb begin
        mute_req  = run_hit;
        atten_req = bias_hit & ~cfg_q.bypass;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!mute_req && !atten_req)); // R1

endmodule

// File: tb/dsd_fault_monitor_tb.sv
module dsd_fault_monitor_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, bit_valid, bit_in, cfg_we, cfg_static_en, cfg_invalid_en, cfg_bypass;
    logic mute_req, atten_req;

    dsd_fault_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .cfg_we(cfg_we), .cfg_static_en(cfg_static_en), .cfg_invalid_en(cfg_invalid_en),
        .cfg_bypass(cfg_bypass), .mute_req(mute_req), .atten_req(atten_req)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    bit m_sen, m_ien, m_byp;
    int m_run, m_fill;
    bit m_prev, m_have;
    bit m_hist[28];

    function automatic int win_ones();
        int c = 0;
        for (int i = 0; i < 28; i++) c += int'(m_hist[i]);
        return c;
    endfunction

    function automatic bit exp_mute();
        return m_sen && (m_run >= 28);
    endfunction

    function automatic bit exp_atten();
        int o = win_ones();
        return m_ien && (m_fill >= 28) && ((o > 24) || (o < 4)) && !m_byp;
    endfunction

    task automatic check(string tag, logic act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_run();
        m_run = 0; m_have = 0; m_prev = 0;
    endtask

    task automatic clear_win();
        for (int i = 0; i < 28; i++) m_hist[i] = 0;
        m_fill = 0;
    endtask

    task automatic model_bit(bit b);
        if (m_sen) begin
            if (!m_have || b != m_prev) m_run = 1;
            else if (m_run < 28) m_run++;
            m_prev = b; m_have = 1;
        end
        if (m_ien) begin
            for (int i = 27; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = b;
            if (m_fill < 28) m_fill++;
        end
    endtask

    // Called at a negedge; leaves at a negedge
    task automatic send_bit(bit b, string tm, string ta);
        bit_valid = 1'b1; bit_in = b;
        @(posedge clk);
        model_bit(b);
        @(negedge clk);
        bit_valid = 1'b0;
        check(tm, mute_req, exp_mute());
        check(ta, atten_req, exp_atten());
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            bit_valid = 1'b0; bit_in = 1'($urandom);
            @(posedge clk);
            @(negedge clk);
            check("R10 mute", mute_req, exp_mute());
            check("R10 atten", atten_req, exp_atten());
        end
    endtask

    task automatic write_cfg(bit s, bit i, bit by);
        cfg_we = 1'b1; cfg_static_en = s; cfg_invalid_en = i; cfg_bypass = by;
        @(posedge clk);
        if (!s) clear_run();
        if (!i) clear_win();
        m_sen = s; m_ien = i; m_byp = by;
        @(negedge clk);
        cfg_we = 1'b0;
        bit_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8 R11 mute", mute_req, exp_mute());
        check("R8 R9 R11 atten", atten_req, exp_atten());
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
        cfg_we = 1'b0; cfg_static_en = 1'b0; cfg_invalid_en = 1'b0; cfg_bypass = 1'b0;
        m_sen = 1; m_ien = 0; m_byp = 0;
        clear_run(); clear_win();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mute after reset", mute_req, 1'b0);
        check("R1 atten after reset", atten_req, 1'b0);

        // R2 boundary, R4 saturation, R3 break; density detector off by default (R1)
        for (int k = 0; k < 27; k++) send_bit(1'b0, "R2 27 bits", "R1 invalid off");
        check("R2 no mute at 27", mute_req, 1'b0);
        send_bit(1'b0, "R2 mute at 28", "R1 invalid off");
        check("R2 mute at 28 direct", mute_req, 1'b1);
        for (int k = 0; k < 40; k++) send_bit(1'b0, "R4 saturated run", "R1 invalid off");
        send_bit(1'b1, "R3 break clears mute", "R1 invalid off");
        check("R3 mute cleared", mute_req, 1'b0);

        // R5 high side, R6 fill, R7 release
        write_cfg(1, 1, 0);
        for (int k = 0; k < 28; k++)
            send_bit((k == 5 || k == 12 || k == 20) ? 1'b0 : 1'b1, "R2 mute",
                     (k < 27) ? "R6 unfilled" : "R5 high 25 ones");
        check("R5 atten with 25 ones", atten_req, 1'b1);
        send_bit(1'b0, "R2 mute", "R7 exactly 24 ones");
        check("R7 atten released", atten_req, 1'b0);

        // R5 low side: 3 ones then 4 ones
        write_cfg(1, 0, 0);
        write_cfg(1, 1, 0);
        for (int k = 0; k < 28; k++)
            send_bit((k == 2 || k == 9 || k == 17) ? 1'b1 : 1'b0, "R2 mute",
                     (k < 27) ? "R6 unfilled" : "R5 low 3 ones");
        check("R5 atten with 3 ones", atten_req, 1'b1);
        send_bit(1'b1, "R2 mute", "R7 exactly 4 ones");
        check("R7 atten at 4 ones", atten_req, 1'b0);

        // R9 bypass masks attenuate, keeps state, mute unaffected
        for (int k = 0; k < 30; k++) send_bit(1'b1, "R2 mute", "R5 biased");
        write_cfg(1, 1, 1);
        check("R9 atten masked", atten_req, 1'b0);
        check("R9 mute unaffected", mute_req, 1'b1);
        send_bit(1'b1, "R9 mute in bypass", "R9 atten in bypass");
        write_cfg(1, 1, 0);
        check("R9 atten returns", atten_req, 1'b1);

        // R8 detectors disabled
        write_cfg(0, 1, 0);
        check("R8 mute off when disabled", mute_req, 1'b0);
        for (int k = 0; k < 35; k++) send_bit(1'b0, "R8 static disabled", "R5 atten");
        write_cfg(0, 0, 0);
        for (int k = 0; k < 35; k++) send_bit(1'b1, "R8 static disabled", "R8 invalid disabled");

        // R11: inputs change without cfg_we
        cfg_static_en = 1'b1; cfg_invalid_en = 1'b1;
        for (int k = 0; k < 30; k++) send_bit(1'b1, "R11 no write mute", "R11 no write atten");

        // R10 idle cycles with toggling data
        write_cfg(1, 1, 0);
        for (int k = 0; k < 20; k++) send_bit(1'b1, "R2 mute", "R6 atten");
        idle(6);
        for (int k = 0; k < 10; k++) send_bit(1'b1, "R4 mute", "R5 atten");
        idle(4);
        send_bit(1'b0, "R3 break after idle", "R5 atten");

        // Random stream with varying bias
        begin
            int pct = 50;
            for (int s = 0; s < 4000; s++) begin
                if (s % 64 == 0) begin
                    case ($urandom % 4)
                        0: pct = 50;
                        1: pct = 94;
                        2: pct = 6;
                        default: pct = 99;
                    endcase
                end
                if ($urandom % 16 == 0) idle(1);
                if ($urandom % 250 == 0)
                    write_cfg(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) == 0);
                send_bit(($urandom % 100) < pct, "R2 random mute", "R5 random atten");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule